// File: doc/BRIEF.md
# Three-Level Space-Vector Switching Sequencer

This block plays out the switching states of one modulation sample for a three-phase inverter whose legs each have three levels (positive bus, neutral, negative bus). It is meant for the overmodulation range, where only the two outer triangles of each major sector carry the reference. A modulator upstream provides, once per sample, the position of the sample inside its sector, the major sector, and three dwell counts in clock cycles. The sequencer then steps through the four timed segments of that sample and drives a level onto every phase.

The order of the segments is fixed by the sample position and by the number of samples per sector, either two or four. Because the order never depends on the reference value, the pulse train stays locked to the fundamental. Patterns exist only for the reference sector. The sequencer derives the other sectors from them with a rotate-and-complement rule. Each pattern ends on the state where the next one begins, so moving from one sample to the next needs no extra transition.

A sample is taken when `valid_i` and `ready_o` are both high at a rising clock edge. `ready_o` stays high while the block is idle. While a sample is playing, `ready_o` rises only during that sample's final cycle, so samples can run back to back with no gap.

Top module: `tlsq_sequencer`

## Requirements
- R1: Each phase output uses a two-bit level code: 01 for positive bus, 00 for neutral, 11 for negative bus. The code 10 never appears.
- R2: While reset is asserted, all three phase outputs are 00, `active_o` is low and `ready_o` is high.
- R3: A sample is accepted only on a rising edge where `valid_i` and `ready_o` are both high. `ready_o` is high whenever the block is idle, and during a running sample it is high only in that sample's final cycle. A `valid_i` raised while `ready_o` is low has no effect on the outputs.
- R4: The first non-empty segment appears on the outputs in the cycle after acceptance. Each segment then holds for its count of cycles. A halved dwell D is split into floor(D/2) cycles for the first half and D − floor(D/2) for the second half. A sample lasts exactly Tx+Ty+Tz cycles.
- R5: With `four_per_sector_i` = 0, only bit 0 of the sample index matters. Index 0 plays (Tx/2, Ty, Tx/2, Tz) with states (0,−,+), (+,−,+), (0,−,+), (0,−,0). Index 1 plays (Tz, Tx/2, Ty, Tx/2) with states (0,−,0), (+,−,0), (+,−,+), (+,−,0). States are listed as (A,B,C) for sector 0.
- R6: With `four_per_sector_i` = 1, index 0 plays the same as R5 index 0, and index 3 plays the same as R5 index 1. Index 1 plays (Tz/2, Tx, Ty, Tz/2) with states (0,−,0), (0,−,+), (+,−,+), (+,0,+). Index 2 plays (Tz/2, Ty, Tx, Tz/2) with states (+,0,+), (+,−,+), (+,−,0), (0,−,0).
- R7: Sector k applies one rotation step k times to every state. One step gives new A = −(old B), new B = −(old C), new C = −(old A), where negation swaps + and − and leaves 0 unchanged. Sector values 6 and 7 behave like 0 and 1.
- R8: When the samples of a sector are played in index order and then continue into the next sector (sector 5 wraps to 0), the first state of every sample equals the last state of the sample before it.
- R9: A segment with a count of zero is skipped and never reaches the outputs. A sample whose three dwells are all zero is accepted, leaves the outputs unchanged and leaves `active_o` low.
- R10: While idle, the phase outputs hold the last state that was driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A sample is offered |
| ready_o | output | 1 | The block takes a sample on this edge |
| four_per_sector_i | input | 1 | 0: two samples per sector, 1: four |
| sample_idx_i | input | 2 | Position of the sample inside its sector |
| sector_i | input | 3 | Major sector, which sets the rotation count |
| dwell_x_i | input | DW | Tx dwell in cycles |
| dwell_y_i | input | DW | Ty dwell in cycles |
| dwell_z_i | input | DW | Tz dwell in cycles |
| phase_a_o | output | 2 | Level code for phase A |
| phase_b_o | output | 2 | Level code for phase B |
| phase_c_o | output | 2 | Level code for phase C |
| active_o | output | 1 | A sample is currently playing |

## Verification
Directed full revolutions in both sample-count modes use nonzero and odd dwells. These show that the rotation step, the segment order and the floor/remainder split are right, and they confirm the state continuity across sample and sector boundaries. Zero-count cases cover a single empty segment, a fully empty sample, and runs of one-cycle samples. They separate correct skipping from a glitch or a stall, and they check that the ready pulse works back to back. Index values 2 and 3 in two-per-sector mode, sector values 6 and 7, and `valid_i` pulsed with unrelated data in the middle of a sample each probe an input that must be ignored or aliased. Random samples with idle gaps are mixed in to cover hold behaviour and arbitrary jumps between patterns.

// File: rtl/tlsq_pkg.sv
package tlsq_pkg;

  typedef logic [1:0] lvl_t;

  localparam lvl_t LV_POS  = 2'b01;
  localparam lvl_t LV_ZERO = 2'b00;
  localparam lvl_t LV_NEG  = 2'b11;

  typedef struct packed {
    lvl_t a;
    lvl_t b;
    lvl_t c;
  } ph_t;

  typedef enum logic [2:0] {
    K_X,
    K_Y,
    K_Z,
    K_X_LO,
    K_X_HI,
    K_Z_LO,
    K_Z_HI
  } dkind_t;

  typedef enum logic [1:0] {
    PAT_EDGE_IN,   // first sample of a sector
    PAT_EDGE_OUT,  // last sample of a sector
    PAT_MID_IN,
    PAT_MID_OUT
  } pat_t;

  // two's complement of the code swaps + and -, keeps 0
  function automatic lvl_t lvl_neg(lvl_t v);
    return lvl_t'(2'b00 - v);
  endfunction

  function automatic ph_t rot_step(ph_t p);
    ph_t r;
    r.a = lvl_neg(p.b);
    r.b = lvl_neg(p.c);
    r.c = lvl_neg(p.a);
    return r;
  endfunction

  function automatic ph_t mk_ph(lvl_t a, lvl_t b, lvl_t c);
    ph_t r;
    r.a = a;
    r.b = b;
    r.c = c;
    return r;
  endfunction

endpackage

// File: rtl/tlsq_pattern.sv
module tlsq_pattern
  import tlsq_pkg::*;
#(
  parameter int unsigned NSEG = 4,
  parameter int unsigned IW   = 2
) (
  input  logic          four_per_sector_i,
  input  logic [IW-1:0] idx_i,
  output ph_t           st_o   [NSEG],
  output dkind_t        kind_o [NSEG]
);

  pat_t pat;

  always_comb begin
    if (four_per_sector_i) begin
      unique case (idx_i[1:0])
        2'd0:    pat = PAT_EDGE_IN;
        2'd1:    pat = PAT_MID_IN;
        2'd2:    pat = PAT_MID_OUT;
        default: pat = PAT_EDGE_OUT;
      endcase
    end else begin
      pat = idx_i[0] ? PAT_EDGE_OUT : PAT_EDGE_IN;
    end
  end

  always_comb begin
    for (int j = 0; j < NSEG; j++) begin
      st_o[j]   = mk_ph(LV_ZERO, LV_ZERO, LV_ZERO);
      kind_o[j] = K_Z;
    end
    unique case (pat)
      PAT_EDGE_IN: begin
        st_o[0] = mk_ph(LV_ZERO, LV_NEG, LV_POS);  kind_o[0] = K_X_LO;
        st_o[1] = mk_ph(LV_POS,  LV_NEG, LV_POS);  kind_o[1] = K_Y;
        st_o[2] = mk_ph(LV_ZERO, LV_NEG, LV_POS);  kind_o[2] = K_X_HI;
        st_o[3] = mk_ph(LV_ZERO, LV_NEG, LV_ZERO); kind_o[3] = K_Z;
      end
      PAT_EDGE_OUT: begin
        st_o[0] = mk_ph(LV_ZERO, LV_NEG, LV_ZERO); kind_o[0] = K_Z;
        st_o[1] = mk_ph(LV_POS,  LV_NEG, LV_ZERO); kind_o[1] = K_X_LO;
        st_o[2] = mk_ph(LV_POS,  LV_NEG, LV_POS);  kind_o[2] = K_Y;
        st_o[3] = mk_ph(LV_POS,  LV_NEG, LV_ZERO); kind_o[3] = K_X_HI;
      end
      PAT_MID_IN: begin
        st_o[0] = mk_ph(LV_ZERO, LV_NEG,  LV_ZERO); kind_o[0] = K_Z_LO;
        st_o[1] = mk_ph(LV_ZERO, LV_NEG,  LV_POS);  kind_o[1] = K_X;
        st_o[2] = mk_ph(LV_POS,  LV_NEG,  LV_POS);  kind_o[2] = K_Y;
        st_o[3] = mk_ph(LV_POS,  LV_ZERO, LV_POS);  kind_o[3] = K_Z_HI;
      end
      default: begin
        st_o[0] = mk_ph(LV_POS,  LV_ZERO, LV_POS);  kind_o[0] = K_Z_LO;
        st_o[1] = mk_ph(LV_POS,  LV_NEG,  LV_POS);  kind_o[1] = K_Y;
        st_o[2] = mk_ph(LV_POS,  LV_NEG,  LV_ZERO); kind_o[2] = K_X;
        st_o[3] = mk_ph(LV_ZERO, LV_NEG,  LV_ZERO); kind_o[3] = K_Z_HI;
      end
    endcase
  end

endmodule

// File: rtl/tlsq_rotator.sv
module tlsq_rotator
  import tlsq_pkg::*;
#(
  parameter int unsigned NSEG = 4,
  parameter int unsigned SW   = 3
) (
  input  logic [SW-1:0] sector_i,
  input  ph_t           st_i [NSEG],
  output ph_t           st_o [NSEG]
);

  localparam int unsigned STAGES = 1 << SW;

  ph_t chain [STAGES][NSEG];

  for (genvar gj = 0; gj < NSEG; gj++) begin : g_seg
    assign chain[0][gj] = st_i[gj];
    for (genvar gs = 1; gs < STAGES; gs++) begin : g_stage
      assign chain[gs][gj] = rot_step(chain[gs-1][gj]);
    end
    assign st_o[gj] = chain[sector_i][gj];
  end

endmodule

// File: rtl/tlsq_dwell_split.sv
module tlsq_dwell_split
  import tlsq_pkg::*;
#(
  parameter int unsigned DW   = 12,
  parameter int unsigned NSEG = 4
) (
  input  logic [DW-1:0] dx_i,
  input  logic [DW-1:0] dy_i,
  input  logic [DW-1:0] dz_i,
  input  dkind_t        kind_i [NSEG],
  output logic [DW-1:0] dur_o  [NSEG]
);

  logic [DW-1:0] x_lo, x_hi, z_lo, z_hi;

  assign x_lo = dx_i >> 1;
  assign x_hi = dx_i - x_lo;
  assign z_lo = dz_i >> 1;
  assign z_hi = dz_i - z_lo;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    always_comb begin
      unique case (kind_i[g])
        K_X:     dur_o[g] = dx_i;
        K_Y:     dur_o[g] = dy_i;
        K_X_LO:  dur_o[g] = x_lo;
        K_X_HI:  dur_o[g] = x_hi;
        K_Z_LO:  dur_o[g] = z_lo;
        K_Z_HI:  dur_o[g] = z_hi;
        default: dur_o[g] = dz_i;
      endcase
    end
  end

endmodule

// File: rtl/tlsq_seg_timer.sv
module tlsq_seg_timer
  import tlsq_pkg::*;
#(
  parameter int unsigned DW   = 12,
  parameter int unsigned NSEG = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] dur_i [NSEG],
  input  ph_t           st_i  [NSEG],
  output ph_t           ph_o,
  output logic          active_o,
  output logic          last_o
);

  localparam int unsigned SIW = (NSEG > 1) ? $clog2(NSEG) : 1;

  logic [DW-1:0]  dur_q [NSEG];
  ph_t            st_q  [NSEG];
  logic [SIW-1:0] seg_q;
  logic [DW-1:0]  cnt_q;
  logic           active_q;
  ph_t            ph_q;

  logic           first_found, next_found, seg_end;
  logic [SIW-1:0] first_idx, next_idx;

  // lowest non-empty segment of the incoming sample
  always_comb begin
    first_found = 1'b0;
    first_idx   = '0;
    for (int j = NSEG - 1; j >= 0; j--) begin
      if (dur_i[j] != '0) begin
        first_found = 1'b1;
        first_idx   = SIW'(j);
      end
    end
  end

  // next non-empty segment after the current one
  always_comb begin
    next_found = 1'b0;
    next_idx   = '0;
    for (int j = NSEG - 1; j >= 0; j--) begin
      if (dur_q[j] != '0 && j > int'(seg_q)) begin
        next_found = 1'b1;
        next_idx   = SIW'(j);
      end
    end
  end

  assign seg_end = active_q && (cnt_q == '0);
  assign last_o  = seg_end && !next_found;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < NSEG; j++) begin
        dur_q[j] <= '0;
        st_q[j]  <= '0;
      end
      seg_q    <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      ph_q     <= '0;
    end else if (load_i) begin
      for (int j = 0; j < NSEG; j++) begin
        dur_q[j] <= dur_i[j];
        st_q[j]  <= st_i[j];
      end
      if (first_found) begin
        active_q <= 1'b1;
        seg_q    <= first_idx;
        cnt_q    <= dur_i[first_idx] - DW'(1);
        ph_q     <= st_i[first_idx];
      end else begin
        active_q <= 1'b0;
      end
    end else if (seg_end) begin
      if (next_found) begin
        seg_q <= next_idx;
        cnt_q <= dur_q[next_idx] - DW'(1);
        ph_q  <= st_q[next_idx];
      end else begin
        active_q <= 1'b0;
      end
    end else if (active_q) begin
      cnt_q <= cnt_q - DW'(1);
    end
  end

  assign ph_o     = ph_q;
  assign active_o = active_q;

endmodule

// File: rtl/tlsq_sequencer.sv
module tlsq_sequencer
  import tlsq_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  output logic          ready_o,
  input  logic          four_per_sector_i,
  input  logic [1:0]    sample_idx_i,
  input  logic [2:0]    sector_i,
  input  logic [DW-1:0] dwell_x_i,
  input  logic [DW-1:0] dwell_y_i,
  input  logic [DW-1:0] dwell_z_i,
  output logic [1:0]    phase_a_o,
  output logic [1:0]    phase_b_o,
  output logic [1:0]    phase_c_o,
  output logic          active_o
);

  localparam int unsigned NSEG = 4;
  localparam int unsigned IW   = 2;
  localparam int unsigned SW   = 3;

  ph_t           ref_st  [NSEG];
  ph_t           rot_st  [NSEG];
  dkind_t        kind    [NSEG];
  logic [DW-1:0] dur     [NSEG];
  ph_t           ph;
  logic          active, last, load;

  tlsq_pattern #(.NSEG(NSEG), .IW(IW)) u_pattern (
    .four_per_sector_i (four_per_sector_i),
    .idx_i             (sample_idx_i),
    .st_o              (ref_st),
    .kind_o            (kind)
  );

  tlsq_rotator #(.NSEG(NSEG), .SW(SW)) u_rotator (
    .sector_i (sector_i),
    .st_i     (ref_st),
    .st_o     (rot_st)
  );

  tlsq_dwell_split #(.DW(DW), .NSEG(NSEG)) u_split (
    .dx_i   (dwell_x_i),
    .dy_i   (dwell_y_i),
    .dz_i   (dwell_z_i),
    .kind_i (kind),
    .dur_o  (dur)
  );

  assign ready_o = !active || last;
  assign load    = valid_i && ready_o;

  tlsq_seg_timer #(.DW(DW), .NSEG(NSEG)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .dur_i    (dur),
    .st_i     (rot_st),
    .ph_o     (ph),
    .active_o (active),
    .last_o   (last)
  );

  assign phase_a_o = ph.a;
  assign phase_b_o = ph.b;
  assign phase_c_o = ph.c;
  assign active_o  = active;

endmodule

// File: rtl/tlsq_sequencer_chk.sv
module tlsq_sequencer_chk #(
  parameter int unsigned DW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic          ready_o,
  input logic [DW-1:0] dwell_x_i,
  input logic [DW-1:0] dwell_y_i,
  input logic [DW-1:0] dwell_z_i,
  input logic [1:0]    phase_a_o,
  input logic [1:0]    phase_b_o,
  input logic [1:0]    phase_c_o,
  input logic          active_o
);

  logic [DW+1:0] dwell_sum;
  assign dwell_sum = {2'b00, dwell_x_i} + {2'b00, dwell_y_i} + {2'b00, dwell_z_i};

  // R1
  legal_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_a_o != 2'b10 && phase_b_o != 2'b10 && phase_c_o != 2'b10);

  // R3
  idle_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> ready_o);

  // R3
  no_early_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !ready_o) |=> active_o);

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !valid_i) |=> (!active_o && $stable({phase_a_o, phase_b_o, phase_c_o})));

  // R9
  empty_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && valid_i && dwell_sum == '0) |=>
      (!active_o && $stable({phase_a_o, phase_b_o, phase_c_o})));

  // R4
  start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && valid_i && dwell_sum != '0) |=> active_o);

endmodule

bind tlsq_sequencer tlsq_sequencer_chk #(.DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .ready_o   (ready_o),
  .dwell_x_i (dwell_x_i),
  .dwell_y_i (dwell_y_i),
  .dwell_z_i (dwell_z_i),
  .phase_a_o (phase_a_o),
  .phase_b_o (phase_b_o),
  .phase_c_o (phase_c_o),
  .active_o  (active_o)
);

// File: tb/tb_tlsq_sequencer.sv
module tb_tlsq_sequencer;

  localparam int DW = 12;
  localparam logic [1:0] LP = 2'b01, LZ = 2'b00, LM = 2'b11;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic          ready_o;
  logic          four_per_sector_i = 1'b0;
  logic [1:0]    sample_idx_i = '0;
  logic [2:0]    sector_i = '0;
  logic [DW-1:0] dwell_x_i = '0, dwell_y_i = '0, dwell_z_i = '0;
  logic [1:0]    phase_a_o, phase_b_o, phase_c_o;
  logic          active_o;

  int checks = 0;
  int errors = 0;
  logic [5:0] prev_st = 6'b0;

  always #2 clk_i = ~clk_i;

  tlsq_sequencer #(.DW(DW)) dut (
    .clk_i, .rst_ni, .valid_i, .ready_o, .four_per_sector_i, .sample_idx_i,
    .sector_i, .dwell_x_i, .dwell_y_i, .dwell_z_i,
    .phase_a_o, .phase_b_o, .phase_c_o, .active_o
  );

  function automatic logic [5:0] phs();
    return {phase_a_o, phase_b_o, phase_c_o};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] ngl(logic [1:0] v);
    return (v == LP) ? LM : (v == LM) ? LP : LZ;
  endfunction

  // R7: k steps of the rotate-and-complement rule, sectors 6/7 alias 0/1
  function automatic logic [5:0] rotk(logic [5:0] s, int k);
    logic [5:0] r = s;
    for (int i = 0; i < k % 6; i++) r = {ngl(r[3:2]), ngl(r[1:0]), ngl(r[5:4])};
    return r;
  endfunction

  // pattern id: 0 first edge, 1 last edge, 2 inner first, 3 inner last (R5, R6)
  function automatic int pat_of(bit n4, int idx);
    if (!n4) return idx % 2;
    case (idx)
      0: return 0;
      1: return 2;
      2: return 3;
      default: return 1;
    endcase
  endfunction

  function automatic logic [5:0] ref_st(int p, int s);
    case (p)
      0: case (s) 0: return {LZ,LM,LP}; 1: return {LP,LM,LP}; 2: return {LZ,LM,LP}; default: return {LZ,LM,LZ}; endcase
      1: case (s) 0: return {LZ,LM,LZ}; 1: return {LP,LM,LZ}; 2: return {LP,LM,LP}; default: return {LP,LM,LZ}; endcase
      2: case (s) 0: return {LZ,LM,LZ}; 1: return {LZ,LM,LP}; 2: return {LP,LM,LP}; default: return {LP,LZ,LP}; endcase
      default: case (s) 0: return {LP,LZ,LP}; 1: return {LP,LM,LP}; 2: return {LP,LM,LZ}; default: return {LZ,LM,LZ}; endcase
    endcase
  endfunction

  // R4: half splits are floor first, remainder second
  function automatic int seg_len(int p, int s, int x, int y, int z);
    case (p)
      0: case (s) 0: return x/2; 1: return y; 2: return x - x/2; default: return z; endcase
      1: case (s) 0: return z; 1: return x/2; 2: return y; default: return x - x/2; endcase
      2: case (s) 0: return z/2; 1: return x; 2: return y; default: return z - z/2; endcase
      default: case (s) 0: return z/2; 1: return y; 2: return x; default: return z - z/2; endcase
    endcase
  endfunction

  // precondition: at a negedge with ready_o high
  task automatic run_sample(input string tag, input bit n4, input int idx, input int sec,
                            input int x, input int y, input int z,
                            input bit glitch, input bit cont);
    int p = pat_of(n4, idx);
    int total = x + y + z;
    int cyc = 0;
    check("R3 ready before offer", ready_o, 1);
    valid_i = 1'b1; four_per_sector_i = n4; sample_idx_i = 2'(idx);
    sector_i = 3'(sec); dwell_x_i = DW'(x); dwell_y_i = DW'(y); dwell_z_i = DW'(z);
    @(posedge clk_i);
    @(negedge clk_i);
    valid_i = 1'b0;
    if (total == 0) begin
      check("R9 empty sample hold", phs(), prev_st);
      check("R9 empty sample idle", active_o, 0);
      check("R9 empty sample ready", ready_o, 1);
      return;
    end
    if (cont) check("R8 continuity", phs(), prev_st);
    for (int s = 0; s < 4; s++) begin
      int d = seg_len(p, s, x, y, z);
      logic [5:0] e = rotk(ref_st(p, s), sec);
      for (int c = 0; c < d; c++) begin
        bit last = (cyc == total - 1);
        check(tag, phs(), e);
        check("R4 active", active_o, 1);
        check("R3 ready pulse", ready_o, last);
        prev_st = e;
        if (glitch && !last) begin
          valid_i = 1'b1; sample_idx_i = 2'($urandom);
          sector_i = 3'($urandom); dwell_x_i = DW'($urandom % 9);
        end else begin
          valid_i = 1'b0;
        end
        cyc++;
        if (!last) @(negedge clk_i);
      end
    end
  endtask

  task automatic idle_gap(input int n);
    valid_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      check("R10 idle hold", phs(), prev_st);
      check("R10 idle ready", ready_o, 1);
      check("R10 idle active", active_o, 0);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    check("R2 reset phases", phs(), 6'b0);
    check("R2 reset active", active_o, 0);
    check("R2 reset ready", ready_o, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R5 R7 R8: full revolution, two per sector, odd halves
    for (int s = 0; s < 6; s++)
      for (int i = 0; i < 2; i++)
        run_sample("R5 two-per-sector", 0, i, s, 5, 3, 4, 0, !(s == 0 && i == 0));
    run_sample("R7 wrap to sector 0", 0, 0, 0, 5, 3, 4, 0, 1);
    idle_gap(2);

    // R6 R7 R8: full revolution, four per sector
    run_sample("R6 four-per-sector", 1, 0, 0, 3, 2, 5, 0, 0);
    for (int i = 1; i < 4; i++) run_sample("R6 four-per-sector", 1, i, 0, 3, 2, 5, 0, 1);
    for (int s = 1; s < 6; s++)
      for (int i = 0; i < 4; i++)
        run_sample("R6 four-per-sector", 1, i, s, 3, 2, 5, 0, 1);
    run_sample("R8 sector 5 to 0", 1, 0, 0, 3, 2, 5, 0, 1);

    // R7: sectors 6 and 7 alias 0 and 1
    run_sample("R7 sector 6", 1, 1, 6, 2, 3, 4, 0, 0);
    run_sample("R7 sector 7", 0, 1, 7, 4, 1, 2, 0, 0);

    // R5: index bit 1 ignored in two-per-sector mode
    run_sample("R5 index 2 aliases 0", 0, 2, 2, 4, 2, 2, 0, 0);
    run_sample("R5 index 3 aliases 1", 0, 3, 3, 4, 2, 2, 0, 0);

    // R9: zero-count segments and empty samples
    run_sample("R9 zero x", 0, 0, 1, 0, 3, 2, 0, 0);
    run_sample("R9 zero z", 0, 1, 4, 3, 2, 0, 0, 0);
    run_sample("R9 zero y", 1, 2, 5, 2, 0, 3, 0, 0);
    run_sample("R9 x of one", 0, 0, 2, 1, 1, 1, 0, 0);
    run_sample("R9 all zero", 1, 1, 3, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) run_sample("R4 one-cycle samples", 1, i, i, 1, 0, 0, 0, 0);
    idle_gap(1);

    // R3: valid with foreign data mid-sample is ignored
    run_sample("R3 ignore valid mid-sample", 1, 2, 1, 4, 5, 6, 1, 0);
    run_sample("R3 ignore valid mid-sample", 0, 1, 4, 7, 3, 5, 1, 0);

    // random mix
    for (int n = 0; n < 300; n++) begin
      int gap = $urandom % 3;
      run_sample("R4 random sample", bit'($urandom % 2), $urandom % 4, $urandom % 8,
                 $urandom % 6, $urandom % 6, $urandom % 6, ($urandom % 4) == 0, 0);
      if (gap != 0) idle_gap(gap);
    end

    idle_gap(2);
    summary();
    $finish;
  end

endmodule